// File: doc/BRIEF.md
# Network PHY Status LED Driver

This block drives one active-high status LED for a single-port Ethernet physical-layer transceiver. It watches six link conditions: speed, transmit activity, receive activity, collision, link state and duplex. A 4-bit display mode picks what the LED shows. The choices are one condition on its own, a fixed test pattern, or a combined view in which a steady primary condition is flipped by a secondary event.

Short events such as a single received frame would be invisible on a lamp. The driver can therefore hold each event for a selectable time of roughly 30, 60 or 100 ms. This hold is a retriggerable one-shot. Pulse stretching can be switched off for the single-event views. The combined views stretch their secondary event in every case.

A small write port loads the mode, the stretch time code and the stretch enable. The same three fields are read back continuously. Every time constant is derived from the `CLK_HZ` parameter.

Top module: `phy_led_driver`

## Requirements
- R1: After a synchronous active-low reset, the readback shows mode 4'b0010 (receive), stretch code 2'b00 and stretch enable 1, and the LED is off while all inputs are low.
- R2: When `cfg_we_i` is high at a clock edge, that edge loads the mode, stretch code and stretch enable, and they appear on the readback ports after that edge.
- R3: Mode 4'b0000 shows speed (1 = 100 Mb/s), mode 4'b0100 shows link up, and mode 4'b0101 shows full duplex. These level conditions are never stretched.
- R4: Mode 4'b0001 shows transmit, 4'b0010 receive, 4'b0011 collision and 4'b0111 receive-or-transmit activity. With stretching enabled each event is stretched. With stretching disabled the LED follows the raw event.
- R5: Stretch code 2'b00 holds an event for 30 ms, 2'b01 for 60 ms and 2'b10 for 100 ms. The reserved code 2'b11 behaves as 30 ms. The hold restarts on every new event and ends only when the full time has passed with no event.
- R6: Mode 4'b1000 forces the LED on and mode 4'b1001 forces it off, whatever the inputs are.
- R7: Mode 4'b1010 blinks with a 100 ms period and mode 4'b1011 with a 500 ms period, both at 50% duty. The LED is on during the first half-period after the mode is entered.
- R8: Mode 4'b1100 shows link flipped by receive, 4'b1101 link flipped by activity and 4'b1110 full duplex flipped by collision. The LED equals the primary condition XOR the stretched secondary event. The secondary event is stretched even when the stretch enable is 0, so with the link down, activity still lights the LED.
- R9: The unused mode codes 4'b0110 and 4'b1111 keep the LED off.
- R10: A write that changes the mode clears every stretch timer and the blink phase at that edge, so the LED shows the new mode from the following clock edge.
- R11: The LED output is registered. It reflects the inputs sampled at a clock edge, and an input change between edges does not reach the LED before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_i | input | 1 | 1 = 100 Mb/s operation |
| link_i | input | 1 | 1 = link up |
| duplex_i | input | 1 | 1 = full duplex |
| tx_i | input | 1 | Transmit event |
| rx_i | input | 1 | Receive event |
| col_i | input | 1 | Collision event |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 4 | Display mode to write |
| cfg_sel_i | input | 2 | Stretch time code to write |
| cfg_str_en_i | input | 1 | Stretch enable to write |
| led_o | output | 1 | LED drive, active high |
| rd_mode_o | output | 4 | Current display mode |
| rd_sel_o | output | 2 | Current stretch time code |
| rd_str_en_o | output | 1 | Current stretch enable |

## Verification
The bench builds the driver with `CLK_HZ = 1000`, so one clock stands for one millisecond. The 30, 60 and 100 ms holds then last exactly 30, 60 and 100 cycles, and the blink half-periods last 50 and 250 cycles. At this scale every stretch duration, each retrigger and both blink edges can be checked at their exact cycle, without running millions of clocks. The mode-change clearing is checked in the middle of a running hold and in the middle of a blink half-period.

// File: rtl/led_pkg.sv
// Package: shared display-mode encoding for the PHY LED driver.
// Assumes: the 4-bit codes are fixed by software expectations.
package led_pkg;

    typedef enum logic [3:0] {
        LM_SPEED   = 4'b0000,
        LM_TX      = 4'b0001,
        LM_RX      = 4'b0010,
        LM_COL     = 4'b0011,
        LM_LINK    = 4'b0100,
        LM_DUPLEX  = 4'b0101,
        LM_SPARE0  = 4'b0110,
        LM_ACT     = 4'b0111,
        LM_ON      = 4'b1000,
        LM_OFF     = 4'b1001,
        LM_BLINK_F = 4'b1010,
        LM_BLINK_S = 4'b1011,
        LM_LNK_RX  = 4'b1100,
        LM_LNK_ACT = 4'b1101,
        LM_DPX_COL = 4'b1110,
        LM_SPARE1  = 4'b1111
    } led_mode_e;

    // Index of each stretched event channel.
    localparam int EV_TX  = 0;
    localparam int EV_RX  = 1;
    localparam int EV_COL = 2;
    localparam int EV_ACT = 3;
    localparam int N_EV   = 4;

endpackage

// File: rtl/led_cfg.sv
// Module: configuration holder for the LED driver.
// Loads mode, stretch code and stretch enable on a write strobe and
// raises clr_o in the cycle of a write that changes the mode.
// Assumes: synchronous active-low reset; write data valid with strobe.
module led_cfg
    import led_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we_i,
    input  logic [3:0] mode_i,
    input  logic [1:0] sel_i,
    input  logic      en_i,
    output led_mode_e mode_o,
    output logic [1:0] sel_o,
    output logic      en_o,
    output logic      clr_o
);

    led_mode_e  mode_q;
    logic [1:0] sel_q;
    logic       en_q;

    // Configuration registers with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LM_RX;
            sel_q  <= 2'b00;
            en_q   <= 1'b1;
        end else if (we_i) begin
            mode_q <= led_mode_e'(mode_i);
            sel_q  <= sel_i;
            en_q   <= en_i;
        end
    end

    // Mode-change pulse that restarts timers downstream.
    always_comb clr_o = we_i && (mode_i != mode_q);

    assign mode_o = mode_q;
    assign sel_o  = sel_q;
    assign en_o   = en_q;

    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (mode_q == LM_RX && sel_q == 2'b00 && en_q));

    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mode_o == $past(mode_i) && sel_o == $past(sel_i) && en_o == $past(en_i)));

endmodule

// File: rtl/led_stretch.sv
// Module: retriggerable one-shot for one LED event.
// act_o is high while the event is present and for len_i cycles after
// its last sampled occurrence; clr_i cancels a running hold.
// Assumes: evt_i synchronous to clk; len_i >= 1 and <= MAX_LEN.
module led_stretch #(
    parameter int MAX_LEN = 100,
    localparam int W = $clog2(MAX_LEN + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         evt_i,
    input  logic [W-1:0] len_i,
    output logic         act_o
);

    logic [W-1:0] cnt_q;

    // Hold counter: reload on event, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= '0;
        else if (evt_i)
            cnt_q <= len_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Stretched view of the event.
    always_comb act_o = evt_i || (cnt_q != '0);

    a_r5_hold_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !clr_i) |=> act_o);

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(MAX_LEN));

    a_r10_clear_timer: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/led_blink.sv
// Module: 50% duty blink generator with two half-period choices.
// on_o is high for the first half-period after clr_i.
// Assumes: FAST_HALF and SLOW_HALF >= 1; slow_i changes only with clr_i.
module led_blink #(
    parameter int FAST_HALF = 50,
    parameter int SLOW_HALF = 250,
    localparam int BW = $clog2(SLOW_HALF + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic slow_i,
    output logic on_o
);

    logic [BW-1:0] cnt_q;
    logic [BW-1:0] half;
    logic          phase_q;

    // Half-period in cycles for the selected rate.
    always_comb half = slow_i ? BW'(SLOW_HALF) : BW'(FAST_HALF);

    // Phase counter, toggling the phase at each half-period end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q >= half - 1'b1) begin
            cnt_q   <= '0;
            phase_q <= !phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb on_o = !phase_q;

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < BW'(SLOW_HALF));

    a_r10_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> on_o);

endmodule

// File: rtl/phy_led_driver.sv
// Module: top of the PHY status LED driver.
// Selects one link condition, test pattern or combined view per the
// display mode, stretches events on request and registers the LED.
// Assumes: all status inputs synchronous to clk; CLK_HZ multiple of 1000.
module phy_led_driver
    import led_pkg::*;
#(
    parameter int CLK_HZ = 25_000_000,
    localparam int TPM     = CLK_HZ / 1000,
    localparam int LEN_30  = 30 * TPM,
    localparam int LEN_60  = 60 * TPM,
    localparam int LEN_100 = 100 * TPM,
    localparam int SW      = $clog2(LEN_100 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       speed_i,
    input  logic       link_i,
    input  logic       duplex_i,
    input  logic       tx_i,
    input  logic       rx_i,
    input  logic       col_i,
    input  logic       cfg_we_i,
    input  logic [3:0] cfg_mode_i,
    input  logic [1:0] cfg_sel_i,
    input  logic       cfg_str_en_i,
    output logic       led_o,
    output logic [3:0] rd_mode_o,
    output logic [1:0] rd_sel_o,
    output logic       rd_str_en_o
);

    led_mode_e       mode;
    logic [1:0]      sel;
    logic            str_en;
    logic            clr;
    logic [SW-1:0]   len;
    logic [N_EV-1:0] raw_ev;
    logic [N_EV-1:0] str_ev;
    logic [N_EV-1:0] single_ev;
    logic            blink_on;
    logic            led_d;

    led_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .mode_i (cfg_mode_i),
        .sel_i  (cfg_sel_i),
        .en_i   (cfg_str_en_i),
        .mode_o (mode),
        .sel_o  (sel),
        .en_o   (str_en),
        .clr_o  (clr)
    );

    // Hold length for the selected stretch code; reserved code acts as 30 ms.
    always_comb begin
        unique case (sel)
            2'b01:   len = SW'(LEN_60);
            2'b10:   len = SW'(LEN_100);
            default: len = SW'(LEN_30);
        endcase
    end

    // Raw event vector in channel order.
    always_comb begin
        raw_ev         = '0;
        raw_ev[EV_TX]  = tx_i;
        raw_ev[EV_RX]  = rx_i;
        raw_ev[EV_COL] = col_i;
        raw_ev[EV_ACT] = tx_i || rx_i;
    end

    for (genvar g = 0; g < N_EV; g++) begin : g_str
        led_stretch #(.MAX_LEN(LEN_100)) u_str (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr),
            .evt_i (raw_ev[g]),
            .len_i (len),
            .act_o (str_ev[g])
        );
    end

    led_blink #(.FAST_HALF(50 * TPM), .SLOW_HALF(250 * TPM)) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .slow_i (mode == LM_BLINK_S),
        .on_o   (blink_on)
    );

    // Single-event views honour the global stretch enable.
    always_comb single_ev = str_en ? str_ev : raw_ev;

    // Display selection per mode.
    always_comb begin
        unique case (mode)
            LM_SPEED:   led_d = speed_i;
            LM_TX:      led_d = single_ev[EV_TX];
            LM_RX:      led_d = single_ev[EV_RX];
            LM_COL:     led_d = single_ev[EV_COL];
            LM_LINK:    led_d = link_i;
            LM_DUPLEX:  led_d = duplex_i;
            LM_ACT:     led_d = single_ev[EV_ACT];
            LM_ON:      led_d = 1'b1;
            LM_OFF:     led_d = 1'b0;
            LM_BLINK_F,
            LM_BLINK_S: led_d = blink_on;
            LM_LNK_RX:  led_d = link_i ^ str_ev[EV_RX];
            LM_LNK_ACT: led_d = link_i ^ str_ev[EV_ACT];
            LM_DPX_COL: led_d = duplex_i ^ str_ev[EV_COL];
            default:    led_d = 1'b0;
        endcase
    end

    // Registered LED output.
    always_ff @(posedge clk) begin
        if (!rst_n) led_o <= 1'b0;
        else        led_o <= led_d;
    end

    assign rd_mode_o   = mode;
    assign rd_sel_o    = sel;
    assign rd_str_en_o = str_en;

    a_r6_force_on: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_ON) |=> led_o);

    a_r6_force_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_OFF) |=> !led_o);

    a_r9_unused_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_SPARE0 || mode == LM_SPARE1) |=> !led_o);

    a_r4_tx_shows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_TX && tx_i) |=> led_o);

    a_r8_link_act_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_LNK_ACT && link_i && (tx_i || rx_i)) |=> !led_o);

    a_r3_link_level: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_LINK) |=> (led_o == $past(link_i)));

endmodule

// File: tb/tb_phy_led_driver.sv
// Scoreboard bench: the driver pushes expected values, a monitor compares.
module tb_phy_led_driver;

    localparam int HZ = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_i = 0, link_i = 0, duplex_i = 0;
    logic       tx_i = 0, rx_i = 0, col_i = 0;
    logic       cfg_we_i = 0;
    logic [3:0] cfg_mode_i = '0;
    logic [1:0] cfg_sel_i = '0;
    logic       cfg_str_en_i = 0;
    logic       led_o;
    logic [3:0] rd_mode_o;
    logic [1:0] rd_sel_o;
    logic       rd_str_en_o;

    phy_led_driver #(.CLK_HZ(HZ)) dut (
        .clk(clk), .rst_n(rst_n), .speed_i(speed_i), .link_i(link_i),
        .duplex_i(duplex_i), .tx_i(tx_i), .rx_i(rx_i), .col_i(col_i),
        .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i), .cfg_sel_i(cfg_sel_i),
        .cfg_str_en_i(cfg_str_en_i), .led_o(led_o), .rd_mode_o(rd_mode_o),
        .rd_sel_o(rd_sel_o), .rd_str_en_o(rd_str_en_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit       is_cfg;
        logic [6:0] exp;
        string    tag;
    } item_t;

    item_t q[$];
    event  smp_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    // Monitor: pops expected items and compares with the ports.
    initial begin
        forever begin
            @(smp_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [6:0] act;
                it  = q.pop_front();
                act = it.is_cfg ? {rd_str_en_o, rd_sel_o, rd_mode_o} : {6'b0, led_o};
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(bit is_cfg, logic [6:0] e, string tag);
        item_t it;
        it.is_cfg = is_cfg;
        it.exp    = e;
        it.tag    = tag;
        q.push_back(it);
        -> smp_ev;
        #1;
    endtask

    task automatic exp_led(bit e, string tag);
        push(1'b0, {6'b0, e}, tag);
    endtask

    // Write configuration; returns after the LED reflects the new mode.
    task automatic cfg_write(logic [3:0] m, logic [1:0] s, bit en);
        cfg_mode_i = m; cfg_sel_i = s; cfg_str_en_i = en; cfg_we_i = 1;
        tick(1);
        cfg_we_i = 0;
        tick(1);
    endtask

    task automatic set_ev(int which, bit v);
        case (which)
            0: tx_i = v;
            1: rx_i = v;
            default: col_i = v;
        endcase
    endtask

    // One-cycle event, then check hold of exactly len cycles.
    task automatic pulse_hold(int which, int len, bit onv, string tag);
        set_ev(which, 1);
        tick(1);
        exp_led(onv, tag);
        set_ev(which, 0);
        tick(len);
        exp_led(onv, tag);
        tick(1);
        exp_led(!onv, tag);
    endtask

    // Watchdog: expiry counts as a failed check.
    initial begin
        #(20000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1: reset values and dark LED.
        push(1'b1, 7'b1_00_0010, "R1 readback");
        exp_led(1'b0, "R1 led");

        // R4/R5: default receive mode, 30 ms hold.
        pulse_hold(1, 30, 1'b1, "R4 R5 rx 30ms");

        // R2: readback after write; R5 60 ms hold on transmit.
        cfg_write(4'b0001, 2'b01, 1'b1);
        push(1'b1, 7'b1_01_0001, "R2 readback");
        pulse_hold(0, 60, 1'b1, "R5 tx 60ms");

        // R5: reserved code 11 behaves as 30 ms.
        cfg_write(4'b0001, 2'b11, 1'b1);
        pulse_hold(0, 30, 1'b1, "R5 reserved code");

        // R5: 100 ms hold on collision.
        cfg_write(4'b0011, 2'b10, 1'b1);
        pulse_hold(2, 100, 1'b1, "R5 col 100ms");

        // R5: retrigger restarts the hold.
        cfg_write(4'b0001, 2'b00, 1'b1);
        tx_i = 1; tick(1); tx_i = 0;
        tick(20);
        exp_led(1'b1, "R5 retrigger mid");
        pulse_hold(0, 30, 1'b1, "R5 retrigger");

        // R4: stretch disabled follows raw activity.
        cfg_write(4'b0111, 2'b00, 1'b0);
        rx_i = 1; tick(1); exp_led(1'b1, "R4 raw act on");
        rx_i = 0; tick(1); exp_led(1'b0, "R4 raw act off");

        // R3 and R11: level conditions and registered output.
        cfg_write(4'b0000, 2'b00, 1'b1);
        speed_i = 1; tick(1); exp_led(1'b1, "R3 speed");
        speed_i = 0; exp_led(1'b1, "R11 no early change");
        tick(1); exp_led(1'b0, "R3 speed off");
        cfg_write(4'b0100, 2'b00, 1'b1);
        link_i = 1; tick(1); exp_led(1'b1, "R3 link");
        cfg_write(4'b0101, 2'b00, 1'b1);
        exp_led(1'b0, "R3 half duplex");
        duplex_i = 1; tick(1); exp_led(1'b1, "R3 full duplex");

        // R6 and R9 with every input high.
        speed_i = 1; tx_i = 1; rx_i = 1; col_i = 1;
        cfg_write(4'b1001, 2'b00, 1'b1);
        exp_led(1'b0, "R6 forced off");
        cfg_write(4'b0110, 2'b00, 1'b1);
        exp_led(1'b0, "R9 code 0110");
        cfg_write(4'b1111, 2'b00, 1'b1);
        exp_led(1'b0, "R9 code 1111");
        speed_i = 0; tx_i = 0; rx_i = 0; col_i = 0; link_i = 0; duplex_i = 0;
        cfg_write(4'b1000, 2'b00, 1'b1);
        exp_led(1'b1, "R6 forced on");

        // R7: fast blink, 50 on / 50 off.
        cfg_write(4'b1010, 2'b00, 1'b1);
        exp_led(1'b1, "R7 fast start");
        tick(49); exp_led(1'b1, "R7 fast end on");
        tick(1);  exp_led(1'b0, "R7 fast off");
        tick(49); exp_led(1'b0, "R7 fast end off");
        tick(1);  exp_led(1'b1, "R7 fast on again");
        // R10: mid-phase switch to slow blink restarts on-phase.
        tick(60);
        exp_led(1'b0, "R7 fast off phase");
        cfg_write(4'b1011, 2'b00, 1'b1);
        exp_led(1'b1, "R10 blink phase cleared");
        tick(249); exp_led(1'b1, "R7 slow end on");
        tick(1);   exp_led(1'b0, "R7 slow off");
        tick(249); exp_led(1'b0, "R7 slow end off");
        tick(1);   exp_led(1'b1, "R7 slow on again");

        // R8: combined views, stretched with enable off.
        link_i = 1;
        cfg_write(4'b1101, 2'b00, 1'b0);
        exp_led(1'b1, "R8 link solid");
        pulse_hold(1, 30, 1'b0, "R8 link act flip");
        link_i = 0; tick(1);
        exp_led(1'b0, "R8 link down dark");
        pulse_hold(0, 30, 1'b1, "R8 act with link down");
        duplex_i = 1;
        cfg_write(4'b1110, 2'b00, 1'b0);
        exp_led(1'b1, "R8 duplex solid");
        pulse_hold(2, 30, 1'b0, "R8 duplex col flip");
        duplex_i = 0; link_i = 1;
        cfg_write(4'b1100, 2'b00, 1'b0);
        tx_i = 1; tick(1); exp_led(1'b1, "R8 tx ignored in link rx");
        tx_i = 0; tick(1);
        pulse_hold(1, 30, 1'b0, "R8 link rx flip");
        link_i = 0;

        // R10: mode change cancels a running hold.
        cfg_write(4'b0010, 2'b00, 1'b1);
        rx_i = 1; tick(1); rx_i = 0;
        tick(5); exp_led(1'b1, "R10 hold running");
        cfg_write(4'b0111, 2'b00, 1'b1);
        exp_led(1'b0, "R10 hold cleared");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule